// File: doc/BRIEF.md
# Byte-Wide Register-Driven I2C Master

This block is an I2C master that software steers one byte at a time through six byte-wide registers. Bus conditions come from edges of control bits rather than from queued commands. Raising the master-select bit while the bus is free produces a START, and dropping it produces a STOP. Setting the restart bit while the block owns the bus produces a repeated START.

Direction comes from the transmit bit. In transmit mode, a write to the data register shifts that byte out. In receive mode, a read of the data register returns the last byte and lets the next byte be clocked in, so the first read after switching direction is a dummy. Software polls a byte-complete flag after every nine-clock transfer and clears it.

The lines are open-drain. The block only asserts output enables that pull SCL or SDA low, and it samples both lines through synchronisers. A bus monitor tracks START and STOP from any master to keep a busy flag. The transmitter flags lost arbitration when a released SDA reads back low. A divider register sets the SCL rate.

Top module: `iic_byte_master`

## Requirements
- R1: After reset, control (address 0) reads 0x00, status (address 1) reads 0x80 (bit 7 set means no byte is in flight), and both line enables are low.
- R2: Control bit 7 is the enable and control bit 5 is master-select. When enabled, a 0-to-1 change of bit 5 with the bus idle produces a START (SDA falls while SCL is high), after which status bit 5 (busy) reads 1.
- R3: With control bit 4 (transmit) set, a write to data (address 2) shifts the byte out MSB first and releases SDA on the ninth clock. At the end of the transfer, status bit 1 sets and status bit 0 holds the ninth-clock SDA level (0 means ACK).
- R4: With control bit 4 clear, a read of data returns the last received byte and starts the next one. On the ninth clock the master drives SDA low (ACK), or leaves it high (NACK) when control bit 3 is set.
- R5: Writing control with bits 2 and 5 set while the bus is owned produces a repeated START with no STOP in between; busy stays 1.
- R6: A 1-to-0 change of control bit 5 produces a STOP once any byte in flight is done, and busy reads 0 after the STOP.
- R7: When the master releases SDA for a 1 data bit and samples it low, it releases both lines, sets status bits 4 and 1, and control bit 5 reads 0.
- R8: A 0-to-1 change of control bit 5 while another master holds the bus produces no START and sets status bits 4 and 1.
- R9: Under the default clear rule, writing 1 to status bit 1 or bit 4 clears that bit, and writes to status bits 0, 5 and 7 have no effect. With the alternate rule, a bit written 0 clears.
- R10: A control write with the enable at its off value releases both lines on the next cycle and abandons the transfer.
- R11: The SCL period is 4*(divider+1) clocks with the high phase half of it; divider is address 3. Within a byte, SDA is never changed by the master while SCL is high.
- R12: The divider (address 3), own-address (address 4) and sampling (address 5) registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid one cycle later |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest cases to reach from the ports are lost arbitration and a busy bus seen from another master, because both need a second agent on the wire. The bench models the bus as a wired-AND of the block's enables and a behavioural target. That target counts SCL falls from the last START, so it can pull SDA low on a chosen bit of a byte the block is sending. A separate flag lets it raise a foreign START and STOP on idle lines. The same wire model feeds a scoreboard that compares every nine-bit frame, ACK included, against the frames the driver queued.

// File: rtl/iic_pkg.sv
package iic_pkg;
  localparam int CB_EN   = 7;
  localparam int CB_MS   = 5;
  localparam int CB_TX   = 4;
  localparam int CB_AK   = 3;
  localparam int CB_RS   = 2;
  localparam int SB_TCF  = 7;
  localparam int SB_BSY  = 5;
  localparam int SB_AL   = 4;
  localparam int SB_IF   = 1;
  localparam int SB_RXAK = 0;
  localparam int BYTE_BITS = 8;
  localparam logic [7:0] CTRL_KEEP = 8'hB8;

  typedef enum logic [1:0] {OP_START, OP_RSTART, OP_STOP, OP_BYTE} iic_op_e;
  typedef enum logic [1:0] {ES_IDLE, ES_HOLD, ES_SEQ, ES_BIT} eng_st_e;
endpackage

// File: rtl/iic_qtick.sv
module iic_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/iic_busmon.sv
module iic_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic busy
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic sda_prev;

  assign scl_s = scl_q[SYNC-1];
  assign sda_s = sda_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= '1;
      sda_q    <= '1;
      sda_prev <= 1'b1;
      busy     <= 1'b0;
    end else begin
      scl_q    <= {scl_q[SYNC-2:0], scl_in};
      sda_q    <= {sda_q[SYNC-2:0], sda_in};
      sda_prev <= sda_s;
      if (scl_s && sda_prev && !sda_s)
        busy <= 1'b1;
      else if (scl_s && !sda_prev && sda_s)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/iic_engine.sv
module iic_engine
  import iic_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  input  logic             op_go,
  input  iic_op_e          op_kind,
  input  logic             op_tx,
  input  logic             op_nack,
  input  logic [7:0]       op_byte,
  input  logic             sda_s,
  output logic             idle,
  output logic             hold,
  output logic             in_bit,
  output logic             byte_done,
  output logic             arb_lost,
  output logic             rx_ack,
  output logic [7:0]       shreg,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int BN_W = $clog2(BYTE_BITS + 1);

  eng_st_e   st;
  iic_op_e   cur_op;
  logic [1:0] phase;
  logic [BN_W-1:0] bitn;
  logic tx_q, nack_q, tick, last_bit;

  assign idle     = (st == ES_IDLE);
  assign hold     = (st == ES_HOLD);
  assign in_bit   = (st == ES_BIT);
  assign last_bit = (bitn == BN_W'(BYTE_BITS));

  iic_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (op_go | clr),
    .div (div),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= ES_IDLE;
      cur_op    <= OP_START;
      phase     <= '0;
      bitn      <= '0;
      tx_q      <= 1'b0;
      nack_q    <= 1'b0;
      shreg     <= '0;
      rx_ack    <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      byte_done <= 1'b0;
      arb_lost  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      arb_lost  <= 1'b0;
      case (st)
        ES_IDLE, ES_HOLD: begin
          if (op_go) begin
            cur_op <= op_kind;
            phase  <= '0;
            bitn   <= '0;
            tx_q   <= op_tx;
            nack_q <= op_nack;
            if (op_kind == OP_BYTE) begin
              st    <= ES_BIT;
              shreg <= op_byte;
            end else begin
              st <= ES_SEQ;
            end
          end
        end
        ES_SEQ: begin
          if (tick) begin
            phase <= phase + 1'b1;
            case (phase)
              2'd0: begin
                if (cur_op == OP_RSTART) sda_oe <= 1'b0;
                if (cur_op == OP_STOP)   sda_oe <= 1'b1;
              end
              2'd1: begin
                if (cur_op == OP_START) sda_oe <= 1'b1;
                else                    scl_oe <= 1'b0;
              end
              2'd2: begin
                if (cur_op == OP_RSTART) sda_oe <= 1'b1;
                if (cur_op == OP_STOP)   sda_oe <= 1'b0;
              end
              default: begin
                if (cur_op == OP_STOP) begin
                  st <= ES_IDLE;
                end else begin
                  scl_oe <= 1'b1;
                  st     <= ES_HOLD;
                end
              end
            endcase
          end
        end
        default: begin
          if (tick) begin
            phase <= phase + 1'b1;
            case (phase)
              2'd0: sda_oe <= last_bit ? (!tx_q && !nack_q) : (tx_q && !shreg[7]);
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (!last_bit) begin
                  if (tx_q && shreg[7] && !sda_s) begin
                    st       <= ES_IDLE;
                    scl_oe   <= 1'b0;
                    sda_oe   <= 1'b0;
                    arb_lost <= 1'b1;
                  end else begin
                    shreg <= {shreg[6:0], sda_s};
                  end
                end else if (tx_q) begin
                  rx_ack <= sda_s;
                end
              end
              default: begin
                scl_oe <= 1'b1;
                if (last_bit) begin
                  st        <= ES_HOLD;
                  byte_done <= 1'b1;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/iic_byte_master.sv
module iic_byte_master
  import iic_pkg::*;
#(
  parameter bit ENABLE_INV = 1'b0,
  parameter bit STATUS_W1C = 1'b1,
  parameter int DIV_W      = 8,
  parameter int SYNC       = 2,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(15)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_DIV  = 3'd3;
  localparam logic [2:0] A_OWN  = 3'd4;
  localparam logic [2:0] A_SAMP = 3'd5;

  logic [7:0] ctrl_q, data_q, own_q, samp_q;
  logic [DIV_W-1:0] div_q;
  logic st_al, st_mif, last_tx;
  logic pend_start, pend_stop, pend_rs, pend_byte, pend_tx;
  logic en_q, en_new, wr_ctrl, dis_wr, eng_clr;
  logic scl_s, sda_s, busy;
  logic eng_idle, eng_hold, in_bit, byte_done, arb_lost, rx_ack;
  logic [7:0] rx_byte;
  logic go;
  iic_op_e go_op;

  assign en_q    = ctrl_q[CB_EN] ^ ENABLE_INV;
  assign en_new  = reg_wdata[CB_EN] ^ ENABLE_INV;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign dis_wr  = wr_ctrl && !en_new;
  assign eng_clr = dis_wr || !en_q;

  iic_busmon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .busy(busy)
  );

  always_comb begin
    go    = 1'b0;
    go_op = OP_BYTE;
    if (eng_idle && pend_start) begin
      go    = 1'b1;
      go_op = OP_START;
    end else if (eng_hold) begin
      if (pend_stop) begin
        go = 1'b1; go_op = OP_STOP;
      end else if (pend_rs) begin
        go = 1'b1; go_op = OP_RSTART;
      end else if (pend_byte) begin
        go = 1'b1; go_op = OP_BYTE;
      end
    end
  end

  iic_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .clr(eng_clr), .div(div_q),
    .op_go(go), .op_kind(go_op), .op_tx(pend_tx), .op_nack(ctrl_q[CB_AK]),
    .op_byte(data_q), .sda_s(sda_s),
    .idle(eng_idle), .hold(eng_hold), .in_bit(in_bit),
    .byte_done(byte_done), .arb_lost(arb_lost), .rx_ack(rx_ack),
    .shreg(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; data_q <= '0; own_q <= '0; samp_q <= '0; div_q <= DIV_RST;
      st_al <= 1'b0; st_mif <= 1'b0; last_tx <= 1'b0;
      pend_start <= 1'b0; pend_stop <= 1'b0; pend_rs <= 1'b0;
      pend_byte <= 1'b0; pend_tx <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (go) begin
        last_tx <= pend_tx;
        case (go_op)
          OP_START:  pend_start <= 1'b0;
          OP_STOP:   pend_stop  <= 1'b0;
          OP_RSTART: pend_rs    <= 1'b0;
          default:   pend_byte  <= 1'b0;
        endcase
      end
      if (eng_idle && !pend_start) begin
        pend_stop <= 1'b0; pend_rs <= 1'b0; pend_byte <= 1'b0;
      end

      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            ctrl_q <= reg_wdata & CTRL_KEEP;
            if (!en_new) begin
              ctrl_q[CB_MS] <= 1'b0;
              pend_start <= 1'b0; pend_stop <= 1'b0;
              pend_rs <= 1'b0; pend_byte <= 1'b0;
            end else begin
              if (reg_wdata[CB_MS] && !ctrl_q[CB_MS]) begin
                if (busy) begin
                  st_al <= 1'b1; st_mif <= 1'b1; ctrl_q[CB_MS] <= 1'b0;
                end else begin
                  pend_start <= 1'b1;
                end
              end
              if (!reg_wdata[CB_MS] && ctrl_q[CB_MS]) pend_stop <= 1'b1;
              if (reg_wdata[CB_RS] && reg_wdata[CB_MS] && ctrl_q[CB_MS]) pend_rs <= 1'b1;
            end
          end
          A_STAT: begin
            if (reg_wdata[SB_AL] == STATUS_W1C) st_al  <= 1'b0;
            if (reg_wdata[SB_IF] == STATUS_W1C) st_mif <= 1'b0;
          end
          A_DATA: begin
            data_q <= reg_wdata;
            if (en_q && ctrl_q[CB_MS] && ctrl_q[CB_TX]) begin
              pend_byte <= 1'b1; pend_tx <= 1'b1;
            end
          end
          A_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
          A_OWN:  own_q  <= reg_wdata;
          A_SAMP: samp_q <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == A_DATA && en_q && ctrl_q[CB_MS] && !ctrl_q[CB_TX]) begin
        pend_byte <= 1'b1; pend_tx <= 1'b0;
      end

      if (byte_done) begin
        st_mif <= 1'b1;
        if (!last_tx) data_q <= rx_byte;
      end
      if (arb_lost) begin
        st_al <= 1'b1; st_mif <= 1'b1; ctrl_q[CB_MS] <= 1'b0;
        pend_stop <= 1'b0; pend_rs <= 1'b0; pend_byte <= 1'b0;
      end

      if (reg_rd) begin
        case (reg_addr)
          A_CTRL: reg_rdata <= ctrl_q;
          A_STAT: reg_rdata <= {!in_bit, 1'b0, busy, st_al, 2'b00, st_mif, rx_ack};
          A_DATA: reg_rdata <= data_q;
          A_DIV:  reg_rdata <= 8'(div_q);
          A_OWN:  reg_rdata <= own_q;
          A_SAMP: reg_rdata <= samp_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/iic_byte_master_chk.sv
module iic_byte_master_chk #(
  parameter bit ENABLE_INV = 1'b0,
  parameter bit STATUS_W1C = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_bit,
  input logic       st_al,
  input logic       st_mif,
  input logic       byte_done,
  input logic       arb_lost
);
  // R11: SDA held steady by the master while SCL is released inside a byte
  p_sda_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (in_bit && $past(in_bit) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R10: disabling releases both lines on the next cycle
  p_disable_frees_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[7] == ENABLE_INV) |=> (!scl_oe && !sda_oe));

  // R7: lost arbitration also raises the byte-complete flag
  p_al_flags_mif_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(st_al) |-> st_mif);

  // R7: the engine report of lost arbitration releases the lines
  p_al_release_r7: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (!scl_oe && !sda_oe));

  // R9: a write of 1 to the byte-complete bit clears it
  p_w1c_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (STATUS_W1C && reg_wr && reg_addr == 3'd1 && reg_wdata[1] && !byte_done && !arb_lost)
      |=> !st_mif);
endmodule

bind iic_byte_master iic_byte_master_chk #(
  .ENABLE_INV(ENABLE_INV),
  .STATUS_W1C(STATUS_W1C)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .in_bit(in_bit), .st_al(st_al), .st_mif(st_mif),
  .byte_done(byte_done), .arb_lost(arb_lost)
);

// File: tb/tb_iic_byte_master.sv
`timescale 1ns/1ps
module tb_iic_byte_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic scl_line, sda_line;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // bus target model
  int   bitcnt = 0;
  bit   slv_tx = 1'b0, slv_ack = 1'b1, arb_on = 1'b0, ext_low = 1'b0;
  int   arb_bit = 1;
  logic [7:0] slv_byte = 8'h00;
  logic slv_drive;
  int   stop_cnt = 0;

  // scoreboard and timing monitor
  logic [8:0] exp_q[$];
  logic [8:0] mon_sh = '0;
  int mon_n = 0;
  int cyc = 0, last_rise = 0, per = 0, hi = 0;

  always #10 clk = ~clk;
  always @(negedge clk) cyc++;

  iic_byte_master dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_comb begin
    slv_drive = 1'b0;
    if (slv_tx && bitcnt >= 0 && bitcnt < 8) slv_drive = !slv_byte[3'(7 - bitcnt)];
    if (!slv_tx && bitcnt == 8 && slv_ack)   slv_drive = 1'b1;
    if (arb_on && bitcnt == arb_bit)         slv_drive = 1'b1;
  end
  assign scl_line = !(scl_oe === 1'b1);
  assign sda_line = !((sda_oe === 1'b1) || slv_drive || ext_low);

  always @(negedge scl_line) begin
    if (bitcnt >= 8) bitcnt = 0; else bitcnt = bitcnt + 1;
    hi = cyc - last_rise;
  end
  always @(negedge sda_line) if (scl_line === 1'b1) begin bitcnt = -1; mon_n = 0; end
  always @(posedge sda_line) if (scl_line === 1'b1) stop_cnt++;

  always @(posedge scl_line) begin
    per = cyc - last_rise;
    last_rise = cyc;
    mon_sh = {mon_sh[7:0], sda_line};
    mon_n++;
    if (mon_n == 9) begin
      mon_n = 0;
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R4 frame: actual %h expected none", mon_sh);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (mon_sh !== e) begin
          fails++;
          $display("FAIL R3/R4 frame: actual %h expected %h", mon_sh, e);
        end
      end
    end
  end

  task automatic push(input logic [7:0] b, input logic nak);
    exp_q.push_back({b, nak});
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mif(input bit clr);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (s[1]) break;
    end
    if (clr) wr(3'd1, 8'h02);
  endtask

  logic [7:0] v;
  int sc;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, v); check("R1 control", v, 8'h00);
    rd(3'd1, v); check("R1 status", v, 8'h80);
    check("R1 line enables", {6'd0, scl_oe, sda_oe}, 8'h00);
    // R12 readback
    wr(3'd3, 8'h07); wr(3'd4, 8'h5A); wr(3'd5, 8'h10);
    rd(3'd3, v); check("R12 divider", v, 8'h07);
    rd(3'd4, v); check("R12 own address", v, 8'h5A);
    rd(3'd5, v); check("R12 sampling", v, 8'h10);
    // R2 start
    wr(3'd0, 8'h80); wr(3'd0, 8'hB0); idle(60);
    rd(3'd1, v); check("R2 busy after START", v & 8'h20, 8'h20);
    // R3 transmit, ACK then NACK; R11 timing
    slv_ack = 1'b1; push(8'hA4, 1'b0); wr(3'd2, 8'hA4); wait_mif(1'b1);
    rd(3'd1, v); check("R3 ACK sampled", v & 8'h81, 8'h80);
    check("R11 SCL period", 8'(per), 8'd32);
    check("R11 SCL high", 8'(hi), 8'd16);
    slv_ack = 1'b0; push(8'h3C, 1'b1); wr(3'd2, 8'h3C); wait_mif(1'b1);
    rd(3'd1, v); check("R3 NACK sampled", v & 8'h01, 8'h01);
    // R5 repeated start
    sc = stop_cnt; slv_ack = 1'b1;
    wr(3'd0, 8'hB4); idle(60);
    check("R5 no STOP", 8'(stop_cnt - sc), 8'd0);
    rd(3'd1, v); check("R5 busy held", v & 8'h20, 8'h20);
    push(8'hA5, 1'b0); wr(3'd2, 8'hA5); wait_mif(1'b1);
    // R4 receive
    wr(3'd0, 8'hA0); slv_tx = 1'b1; slv_byte = 8'h96;
    push(8'h96, 1'b0); rd(3'd2, v); wait_mif(1'b1);
    wr(3'd0, 8'hA8); slv_byte = 8'h5B;
    push(8'h5B, 1'b1); rd(3'd2, v); check("R4 first byte", v, 8'h96);
    wait_mif(1'b1);
    // R6 stop
    slv_tx = 1'b0; sc = stop_cnt;
    wr(3'd0, 8'h88); idle(80);
    rd(3'd2, v); check("R4 last byte", v, 8'h5B);
    rd(3'd1, v); check("R6 busy cleared", v & 8'h20, 8'h00);
    check("R6 STOP seen", 8'(stop_cnt - sc), 8'd1);
    // R7 arbitration loss
    wr(3'd0, 8'hB0); idle(60);
    arb_bit = 1; arb_on = 1'b1; wr(3'd2, 8'hFF); wait_mif(1'b0);
    rd(3'd1, v); check("R7 lost and complete", v & 8'h12, 8'h12);
    rd(3'd0, v); check("R7 master-select cleared", v & 8'h20, 8'h00);
    check("R7 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    arb_on = 1'b0; idle(20);
    wr(3'd1, 8'h12);
    rd(3'd1, v); check("R9 flags cleared", v & 8'h12, 8'h00);
    // R8 foreign master holds the bus; R9 read-only bits
    ext_low = 1'b1; idle(20);
    rd(3'd1, v); check("R8 busy from other master", v & 8'h20, 8'h20);
    wr(3'd1, 8'hA1);
    rd(3'd1, v); check("R9 read-only bits kept", v & 8'hA1, 8'hA0);
    wr(3'd0, 8'hB0); idle(40);
    rd(3'd1, v); check("R8 start refused", v & 8'h12, 8'h12);
    check("R8 no drive", {6'd0, scl_oe, sda_oe}, 8'h00);
    wr(3'd1, 8'h12); ext_low = 1'b0; idle(20);
    // R10 disable mid-byte
    wr(3'd0, 8'hB0); idle(60);
    wr(3'd2, 8'h00); idle(100);
    wr(3'd0, 8'h00);
    check("R10 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    check("R3/R4 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule